// File: doc/BRIEF.md
# Timebase Transfer Target Controller

This block sits beside a chip's time-of-day logic and steers a one-shot transfer of the current time into the timebase of exactly one core. Software first writes a 64-bit target word to the target-control offset. The block decodes that word into a core index and latches it together with a valid flag. A later write to the move offset hands the time over. The hand-over happens only when the time-of-day machine is running, the move word carries its arm bit, a target is latched and that core says it is ready. The hand-over is a one-cycle pulse on the chosen core's sent line.

Two addressing forms are decoded. In full-address form the upper word of the write is a complete register address. It must name the timebase receive register at offset 0x4A3, and the bits above the low 12 must equal one core's base address. In short form a small core ID picks the core. A build-time parameter selects between two variants: one accepts both forms, the other accepts only full-address form. Every refused command sets its own sticky error bit, which stays set until reset.

Top module: `tbx_xfer_ctrl`

## Requirements
- R1: After reset, tgtValid is 0, tbSent is all zero, errFlags is all zero and rdValid is 0.
- R2: A write to offset 0x27 with wrData[28] set (bit 35 counting from the MSB) uses full-address form. The address is wrData[63:32]. If wrData[43:32] equals 0x4A3 and {wrData[63:44], 12'h000} equals the base of core i, then from the next cycle tgtValid is 1 and tgtIdx is i.
- R3: In full-address form, a register field other than 0x4A3 or an address that matches no core base makes the target invalid. From the next cycle tgtValid is 0 and errFlags[0] is set.
- R4: A write to offset 0x27 with wrData[28] clear uses short form. The core ID is wrData[36:32], which is the field at MSB-0 bits 26..31 with its top bit (wrData[37]) dropped. It selects the core whose configured ID matches. If no core matches, tgtValid is cleared and errFlags[0] is set.
- R5: With ALLOW_CORE_ID = 0, every short-form write is an invalid target: tgtValid is cleared and errFlags[0] is set.
- R6: A write to offset 0x17 is accepted when four conditions all hold: todRunning is 1, wrData[63] (MSB-0 bit 0) is 1, tgtValid is 1 and coreReady[tgtIdx] is 1. When it is accepted, tbSent is one-hot on bit tgtIdx for exactly the next cycle and is zero otherwise.
- R7: A refused move leaves tbSent at zero and sets one error bit, chosen by the first failing check in this order: not running sets errFlags[1], arm bit clear sets errFlags[2], no valid target sets errFlags[3], and core not ready sets errFlags[4].
- R8: Error bits are sticky. Once set, a bit stays 1 until reset, and reset clears all of them.
- R9: A read of offset 0x27 or 0x17 gives rdValid = 1 in the next cycle with rdData equal to zero. A read of any other offset leaves rdValid at 0.
- R10: The latched target (tgtValid, tgtIdx) changes only on a write to offset 0x27. Writes to other offsets, and moves, leave it and errFlags unchanged except as R7 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write offset, in units of 8 bytes |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Read offset, in units of 8 bytes |
| todRunning | input | 1 | Time-of-day machine is in its running state |
| coreReady | input | NUM_CORES | Per-core ready-to-receive flag |
| rdData | output | 64 | Read data, always zero for decoded offsets |
| rdValid | output | 1 | Read data valid, one cycle after a decoded read |
| tgtValid | output | 1 | A valid target is latched |
| tgtIdx | output | IDX_W | Index of the latched target core |
| tbSent | output | NUM_CORES | One-cycle per-core time-sent pulse |
| errFlags | output | 5 | Sticky error bits (target, not running, not armed, no target, not ready) |

## Verification
The hardest case to reach is the deepest move refusal: the time machine is running, the arm bit is set and a target is latched, but that core is not ready. Only then can errFlags[4] be set. The stimulus first latches a full-address target, then issues refused moves that fail each earlier guard in turn. It then drops only that core's ready flag before the arm-bit move. Finally it raises the flag and repeats the move to see the pulse. A second instance built as the full-address-only variant receives the same writes, so each short-form write checks both variants against each other.

// File: rtl/tbx_pkg.sv
package tbx_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned ERR_W      = 5;
  // error bit positions
  localparam int unsigned ERR_TARGET = 0;
  localparam int unsigned ERR_STATE  = 1;
  localparam int unsigned ERR_ARG    = 2;
  localparam int unsigned ERR_NOTGT  = 3;
  localparam int unsigned ERR_NOTRDY = 4;
  // field positions in LSB-0 numbering
  localparam int unsigned MODE_BIT   = 28;  // MSB-0 bit 35
  localparam int unsigned ARM_BIT    = 63;  // MSB-0 bit 0
  localparam int unsigned ADDR_LSB   = 32;
  localparam int unsigned ID_W       = 5;

  typedef struct packed {
    logic             tgtWrite;
    logic             moveFire;
    logic             rdAck;
    logic [ERR_W-1:0] errSet;
  } strobe_t;
endpackage

// File: rtl/tbx_xfer_dp.sv
module tbx_xfer_dp
  import tbx_pkg::*;
#(
  parameter int unsigned               NUM_CORES     = 4,
  parameter int unsigned               IDX_W         = 2,
  parameter logic [NUM_CORES*32-1:0]   CORE_BASES    = '0,
  parameter logic [NUM_CORES*ID_W-1:0] CORE_IDS      = '0,
  parameter bit                        ALLOW_CORE_ID = 1'b1,
  parameter logic [11:0]               RX_REG        = 12'h4A3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_W-1:0]    wrData,
  input  strobe_t              strb,
  input  logic [NUM_CORES-1:0] coreReady,
  output logic                 candValid,
  output logic                 tgtValid,
  output logic [IDX_W-1:0]     tgtIdx,
  output logic                 tgtReady,
  output logic [NUM_CORES-1:0] tbSent,
  output logic                 rdValid,
  output logic [WORD_W-1:0]    rdData
);
  logic             fullMode;
  logic [31:0]      fullAddr;
  logic             regOk;
  logic [ID_W-1:0]  coreId;
  logic [NUM_CORES-1:0] baseHit, idHit, idSel, hitVec, selOh;
  logic [IDX_W-1:0] candIdx;
  logic             tgtValidQ, rdValidQ;
  logic [IDX_W-1:0] tgtIdxQ;
  logic [NUM_CORES-1:0] tbSentQ;
  logic             unusedBits;

  assign fullMode   = wrData[MODE_BIT];
  assign fullAddr   = wrData[ADDR_LSB +: 32];
  assign regOk      = (fullAddr[11:0] == RX_REG);
  assign coreId     = wrData[ADDR_LSB +: ID_W];
  assign unusedBits = ^{wrData[31:29], wrData[27:0]};

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_match
    assign baseHit[i] = (CORE_BASES[i*32 +: 32] == {fullAddr[31:12], 12'h000});
    assign idHit[i]   = (CORE_IDS[i*ID_W +: ID_W] == coreId);
  end

  if (ALLOW_CORE_ID) begin : g_idMode
    assign idSel = idHit;
  end else begin : g_fullOnly
    assign idSel = '0;
  end

  assign hitVec = fullMode ? (regOk ? baseHit : '0) : idSel;

  always_comb begin
    candValid = |hitVec;
    candIdx   = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (hitVec[i]) candIdx = IDX_W'(i);
    end
  end

  assign selOh    = NUM_CORES'(1) << tgtIdxQ;
  assign tgtReady = |(coreReady & selOh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtValidQ <= 1'b0;
      tgtIdxQ   <= '0;
      tbSentQ   <= '0;
      rdValidQ  <= 1'b0;
    end else begin
      if (strb.tgtWrite) begin
        tgtValidQ <= candValid;
        tgtIdxQ   <= candIdx;
      end
      tbSentQ  <= strb.moveFire ? selOh : '0;
      rdValidQ <= strb.rdAck;
    end
  end

  assign tgtValid = tgtValidQ;
  assign tgtIdx   = tgtIdxQ;
  assign tbSent   = tbSentQ;
  assign rdValid  = rdValidQ;
  assign rdData   = '0;
endmodule

// File: rtl/tbx_xfer_ctl.sv
module tbx_xfer_ctl
  import tbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter logic [5:0]  TGT_OFS  = 6'h27,
  parameter logic [5:0]  MOVE_OFS = 6'h17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              moveArm,
  input  logic              todRunning,
  input  logic              candValid,
  input  logic              tgtValid,
  input  logic              tgtReady,
  output strobe_t           strb,
  output logic [ERR_W-1:0]  errFlags
);
  localparam logic [ADDR_W-1:0] TGT_A  = ADDR_W'(TGT_OFS);
  localparam logic [ADDR_W-1:0] MOVE_A = ADDR_W'(MOVE_OFS);

  logic [ERR_W-1:0] errQ;

  always_comb begin
    strb       = '0;
    strb.rdAck = rdEn && ((rdAddr == TGT_A) || (rdAddr == MOVE_A));
    if (wrEn && (wrAddr == TGT_A)) begin
      strb.tgtWrite           = 1'b1;
      strb.errSet[ERR_TARGET] = !candValid;
    end else if (wrEn && (wrAddr == MOVE_A)) begin
      if (!todRunning)    strb.errSet[ERR_STATE]  = 1'b1;
      else if (!moveArm)  strb.errSet[ERR_ARG]    = 1'b1;
      else if (!tgtValid) strb.errSet[ERR_NOTGT]  = 1'b1;
      else if (!tgtReady) strb.errSet[ERR_NOTRDY] = 1'b1;
      else                strb.moveFire           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= '0;
    else       errQ <= errQ | strb.errSet;
  end

  assign errFlags = errQ;
endmodule

// File: rtl/tbx_xfer_ctrl.sv
module tbx_xfer_ctrl
  import tbx_pkg::*;
#(
  parameter int unsigned               NUM_CORES     = 4,
  parameter int unsigned               ADDR_W        = 6,
  parameter bit                        ALLOW_CORE_ID = 1'b1,
  parameter logic [NUM_CORES*32-1:0]   CORE_BASES    = {32'h2300_0000, 32'h2200_0000,
                                                        32'h2100_0000, 32'h2000_0000},
  parameter logic [NUM_CORES*ID_W-1:0] CORE_IDS      = {5'd7, 5'd5, 5'd2, 5'd0},
  parameter logic [5:0]                TGT_OFS       = 6'h27,
  parameter logic [5:0]                MOVE_OFS      = 6'h17,
  parameter logic [11:0]               RX_REG        = 12'h4A3,
  localparam int unsigned              IDX_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [63:0]          wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 todRunning,
  input  logic [NUM_CORES-1:0] coreReady,
  output logic [63:0]          rdData,
  output logic                 rdValid,
  output logic                 tgtValid,
  output logic [IDX_W-1:0]     tgtIdx,
  output logic [NUM_CORES-1:0] tbSent,
  output logic [4:0]           errFlags
);
  strobe_t strb;
  logic    candValid;
  logic    tgtReady;

  tbx_xfer_ctl #(
    .ADDR_W(ADDR_W), .TGT_OFS(TGT_OFS), .MOVE_OFS(MOVE_OFS)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .moveArm(wrData[ARM_BIT]),
    .todRunning(todRunning), .candValid(candValid), .tgtValid(tgtValid),
    .tgtReady(tgtReady), .strb(strb), .errFlags(errFlags)
  );

  tbx_xfer_dp #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CORE_BASES(CORE_BASES),
    .CORE_IDS(CORE_IDS), .ALLOW_CORE_ID(ALLOW_CORE_ID), .RX_REG(RX_REG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb),
    .coreReady(coreReady), .candValid(candValid), .tgtValid(tgtValid),
    .tgtIdx(tgtIdx), .tgtReady(tgtReady), .tbSent(tbSent),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/tbx_xfer_ctrl_chk.sv
module tbx_xfer_ctrl_chk #(
  parameter int unsigned NUM_CORES     = 4,
  parameter int unsigned ADDR_W        = 6,
  parameter bit          ALLOW_CORE_ID = 1'b1,
  parameter logic [5:0]  TGT_OFS       = 6'h27,
  parameter logic [5:0]  MOVE_OFS      = 6'h17,
  parameter logic [11:0] RX_REG        = 12'h4A3,
  localparam int unsigned IDX_W        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [63:0]          wrData,
  input logic                 todRunning,
  input logic [NUM_CORES-1:0] coreReady,
  input logic                 tgtValid,
  input logic [IDX_W-1:0]     tgtIdx,
  input logic [NUM_CORES-1:0] tbSent,
  input logic [4:0]           errFlags
);
  localparam logic [ADDR_W-1:0] TGT_A  = ADDR_W'(TGT_OFS);
  localparam logic [ADDR_W-1:0] MOVE_A = ADDR_W'(MOVE_OFS);

  logic tgtWr, moveWr;
  assign tgtWr  = wrEn && (wrAddr == TGT_A);
  assign moveWr = wrEn && (wrAddr == MOVE_A);

  a_r6_sent_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tbSent));

  a_r6_sent_cause: assert property (@(posedge clk) disable iff (!rstN)
    (|tbSent) |-> $past(moveWr && todRunning && wrData[63] && tgtValid));

  a_r6_sent_target: assert property (@(posedge clk) disable iff (!rstN)
    (|tbSent) |-> (tbSent == (NUM_CORES'(1) << $past(tgtIdx))) && $past(coreReady) == ($past(coreReady) | tbSent));

  a_r7_not_running: assert property (@(posedge clk) disable iff (!rstN)
    (moveWr && !todRunning) |=> (tbSent == '0) && errFlags[1]);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags & $past(errFlags)) == $past(errFlags));

  a_r3_bad_reg: assert property (@(posedge clk) disable iff (!rstN)
    (tgtWr && wrData[28] && (wrData[43:32] != RX_REG)) |=> !tgtValid && errFlags[0]);

  a_r5_full_only: assert property (@(posedge clk) disable iff (!rstN)
    (!ALLOW_CORE_ID && tgtWr && !wrData[28]) |=> !tgtValid && errFlags[0]);

  a_r10_target_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tgtWr |=> $stable(tgtValid) && $stable(tgtIdx));
endmodule

bind tbx_xfer_ctrl tbx_xfer_ctrl_chk #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .ALLOW_CORE_ID(ALLOW_CORE_ID),
  .TGT_OFS(TGT_OFS), .MOVE_OFS(MOVE_OFS), .RX_REG(RX_REG)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .todRunning(todRunning), .coreReady(coreReady), .tgtValid(tgtValid),
  .tgtIdx(tgtIdx), .tbSent(tbSent), .errFlags(errFlags)
);

// File: tb/tbx_xfer_ctrl_tb_top.sv
module tbx_xfer_ctrl_tb_top;
  localparam int NC = 4;
  localparam logic [NC*32-1:0] BASES = {32'h2300_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000};
  localparam logic [NC*5-1:0]  IDS   = {5'd7, 5'd5, 5'd2, 5'd0};
  localparam logic [5:0] TGT  = 6'h27;
  localparam logic [5:0] MOVE = 6'h17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        wrEn = 0, rdEn = 0, todRunning = 0;
  logic [5:0]  wrAddr = '0, rdAddr = '0;
  logic [63:0] wrData = '0;
  logic [NC-1:0] coreReady = '0;

  logic [63:0] rdDataA, rdDataB;
  logic        rdValidA, rdValidB, tgtValidA, tgtValidB;
  logic [1:0]  tgtIdxA, tgtIdxB;
  logic [NC-1:0] tbSentA, tbSentB;
  logic [4:0]  errFlagsA, errFlagsB;

  tbx_xfer_ctrl #(.NUM_CORES(NC), .ALLOW_CORE_ID(1'b1), .CORE_BASES(BASES), .CORE_IDS(IDS)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .todRunning(todRunning), .coreReady(coreReady),
    .rdData(rdDataA), .rdValid(rdValidA), .tgtValid(tgtValidA), .tgtIdx(tgtIdxA),
    .tbSent(tbSentA), .errFlags(errFlagsA));

  tbx_xfer_ctrl #(.NUM_CORES(NC), .ALLOW_CORE_ID(1'b0), .CORE_BASES(BASES), .CORE_IDS(IDS)) dut_v (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .todRunning(todRunning), .coreReady(coreReady),
    .rdData(rdDataB), .rdValid(rdValidB), .tgtValid(tgtValidB), .tgtIdx(tgtIdxB),
    .tbSent(tbSentB), .errFlags(errFlagsB));

  typedef struct {
    int           due;
    string        req;
    bit           v[2];
    int           idx[2];
    logic [3:0]   sent[2];
    logic [4:0]   err[2];
    bit           rdv;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  bit         mV[2];
  int         mIdx[2];
  logic [4:0] mErr[2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fullW(input logic [31:0] a);
    return {a, 32'h1000_0000};
  endfunction
  function automatic logic [63:0] idW(input logic [5:0] id);
    return {26'h0, id, 32'h0};
  endfunction
  function automatic logic [63:0] mvW(input bit arm);
    return {arm, 63'h0};
  endfunction

  function automatic void decodeRef(input logic [63:0] d, input bit allowId,
                                    output bit ok, output int idx);
    ok = 0; idx = 0;
    if (d[28]) begin
      if (d[43:32] == 12'h4A3) begin
        for (int i = 0; i < NC; i++)
          if (!ok && BASES[i*32 +: 32] == {d[63:44], 12'h000}) begin ok = 1; idx = i; end
      end
    end else if (allowId) begin
      for (int i = 0; i < NC; i++)
        if (!ok && IDS[i*5 +: 5] == d[36:32]) begin ok = 1; idx = i; end
    end
  endfunction

  task automatic pushExp(input string req, input logic [3:0] s0, input logic [3:0] s1, input bit rdv);
    exp_t e;
    e.due = cyc + 1;
    e.req = req;
    e.rdv = rdv;
    for (int k = 0; k < 2; k++) begin
      e.v[k] = mV[k]; e.idx[k] = mIdx[k]; e.err[k] = mErr[k];
    end
    e.sent[0] = s0; e.sent[1] = s1;
    q.push_back(e);
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d, input bit run,
                    input logic [3:0] rdy, input string req);
    logic [3:0] s[2];
    @(posedge clk); #1;
    wrEn = 1; wrAddr = a; wrData = d; rdEn = 0; todRunning = run; coreReady = rdy;
    for (int k = 0; k < 2; k++) begin
      bit ok; int idx;
      s[k] = '0;
      if (a == TGT) begin
        decodeRef(d, k == 0, ok, idx);
        mV[k] = ok; mIdx[k] = idx;
        if (!ok) mErr[k][0] = 1'b1;
      end else if (a == MOVE) begin
        if (!run)                mErr[k][1] = 1'b1;
        else if (!d[63])         mErr[k][2] = 1'b1;
        else if (!mV[k])         mErr[k][3] = 1'b1;
        else if (!rdy[mIdx[k]])  mErr[k][4] = 1'b1;
        else                     s[k] = 4'(1 << mIdx[k]);
      end
    end
    pushExp(req, s[0], s[1], 1'b0);
  endtask

  task automatic rd(input logic [5:0] a, input bit expV, input string req);
    @(posedge clk); #1;
    wrEn = 0; rdEn = 1; rdAddr = a;
    pushExp(req, 4'h0, 4'h0, expV);
  endtask

  task automatic idle(input string req);
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0;
    pushExp(req, 4'h0, 4'h0, 1'b0);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic checkReset(input string req);
    check(tgtValidA == 0 && tgtValidB == 0, req, "tgtValid after reset", {tgtValidA, tgtValidB}, 0);
    check(tbSentA == 0 && tbSentB == 0, req, "tbSent after reset", {tbSentA, tbSentB}, 0);
    check(errFlagsA == 0 && errFlagsB == 0, req, "errFlags after reset", {errFlagsA, errFlagsB}, 0);
    check(rdValidA == 0 && rdValidB == 0, req, "rdValid after reset", {rdValidA, rdValidB}, 0);
  endtask

  task automatic doReset(input string req);
    @(posedge clk); #1;
    rstN = 0; wrEn = 0; rdEn = 0;
    for (int k = 0; k < 2; k++) begin mV[k] = 0; mIdx[k] = 0; mErr[k] = '0; end
    @(negedge clk);
    checkReset(req);
    @(posedge clk); #1;
    rstN = 1;
  endtask

  // monitor: compares the scoreboard head once its result is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit         ov[2];
      int         oi[2];
      logic [3:0] os[2];
      logic [4:0] oe[2];
      bit         orv[2];
      logic [63:0] ord[2];
      e = q.pop_front();
      ov[0] = tgtValidA; ov[1] = tgtValidB;
      oi[0] = int'(tgtIdxA); oi[1] = int'(tgtIdxB);
      os[0] = tbSentA;   os[1] = tbSentB;
      oe[0] = errFlagsA; oe[1] = errFlagsB;
      orv[0] = rdValidA; orv[1] = rdValidB;
      ord[0] = rdDataA;  ord[1] = rdDataB;
      for (int k = 0; k < 2; k++) begin
        string tag;
        tag = (k == 0) ? "[both modes]" : "[full only]";
        check(ov[k] == e.v[k], e.req, {"tgtValid ", tag}, ov[k], e.v[k]);
        if (e.v[k]) check(oi[k] == e.idx[k], e.req, {"tgtIdx ", tag}, oi[k], e.idx[k]);
        check(os[k] == e.sent[k], e.req, {"tbSent ", tag}, os[k], e.sent[k]);
        check(oe[k] == e.err[k], e.req, {"errFlags ", tag}, oe[k], e.err[k]);
        check(orv[k] == e.rdv, e.req, {"rdValid ", tag}, orv[k], e.rdv);
        if (e.rdv) check(ord[k] == 64'h0, e.req, {"rdData ", tag}, ord[k], 0);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100us;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset("R1");

    // R9: reads of decoded offsets return zero, others are not answered
    rd(TGT, 1'b1, "R9");
    rd(MOVE, 1'b1, "R9");
    rd(6'h05, 1'b0, "R9");

    // R7: move with nothing latched
    wr(MOVE, mvW(1), 1'b1, 4'hF, "R7");

    // R2: full-address target core 2
    wr(TGT, fullW(32'h2200_04A3), 1'b1, 4'hF, "R2");

    // R7: guard order, each refusal sets its own bit
    wr(MOVE, mvW(1), 1'b0, 4'hF, "R7");
    wr(MOVE, mvW(0), 1'b1, 4'hF, "R7");
    wr(MOVE, mvW(1), 1'b1, 4'b1011, "R7");

    // R6: accepted move, then pulse ends
    wr(MOVE, mvW(1), 1'b1, 4'b0100, "R6");
    idle("R6");

    // R4 / R5: short-form target
    wr(TGT, idW(6'd7), 1'b1, 4'hF, "R4");
    wr(MOVE, mvW(1), 1'b1, 4'hF, "R5");
    wr(TGT, idW(6'h25), 1'b1, 4'hF, "R4");
    wr(MOVE, mvW(1), 1'b1, 4'hF, "R4");
    wr(TGT, idW(6'd3), 1'b1, 4'hF, "R4");

    // R3: bad register field, and no matching base
    wr(TGT, fullW(32'h2100_04A4), 1'b1, 4'hF, "R3");
    wr(TGT, fullW(32'h2200_04A3), 1'b1, 4'hF, "R2");
    wr(TGT, fullW(32'h2500_04A3), 1'b1, 4'hF, "R3");

    // R10: other offsets leave the target alone
    wr(TGT, fullW(32'h2100_04A3), 1'b1, 4'hF, "R2");
    wr(6'h10, fullW(32'h2300_04A3), 1'b1, 4'hF, "R10");
    wr(6'h18, mvW(1), 1'b1, 4'hF, "R10");
    wr(MOVE, mvW(1), 1'b1, 4'hF, "R6");
    wr(MOVE, mvW(1), 1'b1, 4'hF, "R6");
    idle("R10");
    idle("R8");
    drain();

    // R8: errors hold until reset, then clear
    doReset("R8");
    wr(TGT, fullW(32'h2000_04A3), 1'b1, 4'h1, "R2");
    wr(MOVE, mvW(1), 1'b1, 4'h1, "R6");
    idle("R6");
    drain();

    finishRun();
  end
endmodule